// File: doc/BRIEF.md
# Instruction Field Decoder and Scratchpad Address Generator

This block is a single pipelined stage that accepts one 64-bit instruction word per handshake. It breaks the word into an opcode byte, a destination index, a source index, a modifier byte and a 32-bit immediate. From these it decides whether the source operand is a register or the immediate. The immediate is widened to 64 bits with sign extension.

The stage also forms a scratchpad byte address. It masks an address base, which is the chosen source operand, with a mask that depends on the scratchpad level. An immediate source always selects the largest level. The condition selector from the modifier byte goes to the execute stage unchanged.

The register file sits outside the block. The stage drives the source index straight from the incoming word and takes the register value back in the same cycle. All results are registered. They stay stable while the downstream stage is not ready.

Top module: `insn_decode_agen`

## Requirements
- R1: The word is little-endian. The opcode is bits [7:0], the destination byte is bits [15:8], the source byte is bits [23:16], the modifier byte is bits [31:24], and the immediate is bits [63:32]. `outDst` and `outSrc` are the low 3 bits of their byte when `idxWide`=1. When `idxWide`=0 they are the low 2 bits with bit 2 forced to 0.
- R2: `outUseImm` is 1 when the destination and source indices are equal. The comparison uses bits [2:0] when `idxWide`=1 and bits [1:0] when `idxWide`=0. Higher bits of both bytes are ignored.
- R3: `outImm` is the immediate sign-extended to 64 bits. `outSrcOperand` equals `outImm` when `outUseImm`=1 and otherwise equals the captured `rfReadData`.
- R4: `outCond` equals modifier bits [4:2]. Modifier bits [7:5] have no effect on any output.
- R5: `outLevel` is 3 (mask 0x1FFFF8) when the immediate is used. Otherwise it is 2 (mask 0x3FFF8) when modifier bits [1:0] are 0, and 1 (mask 0x3FF8) for modifier bits [1:0] of 1 to 3.
- R6: `outMemAddr` is the bitwise AND of `outSrcOperand[20:0]` and the mask of the selected level.
- R7: `rfReadIdx` equals bits [18:16] of `inWord` in the same cycle, with no register in the path.
- R8: `inReady` is high when `outValid` is low or `outReady` is high. A word accepted on a clock edge appears on the outputs after that edge, with `outValid` high. `outValid` falls after an edge where `outReady` is high and no word is accepted.
- R9: While `outValid`=1 and `outReady`=0, all outputs keep their values and a presented word is not taken.
- R10: After reset, `outValid` is 0, `inReady` is 1, and every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Stage can accept a word |
| inWord | input | 64 | Instruction word |
| idxWide | input | 1 | 1: 3-bit register indices, 0: 2-bit indices |
| rfReadIdx | output | 3 | Source register index to the register file |
| rfReadData | input | 64 | Register value for `rfReadIdx` |
| outValid | output | 1 | Decoded result valid |
| outReady | input | 1 | Downstream accepts the result |
| outOpcode | output | 8 | Opcode byte |
| outDst | output | 3 | Destination index |
| outSrc | output | 3 | Source index |
| outUseImm | output | 1 | Source operand is the immediate |
| outImm | output | 64 | Sign-extended immediate |
| outSrcOperand | output | 64 | Selected source operand |
| outMemAddr | output | 21 | Masked scratchpad address |
| outLevel | output | 2 | Scratchpad level: 1, 2 or 3 |
| outCond | output | 3 | Condition selector |

## Verification
Random words are sent with the source byte often copied from the destination byte. This covers both the immediate path and the register path. The random runs use both index widths and random register values.

Directed words separate three pairs of cases:
- Indices that match only in bits [1:0] produce an immediate source under narrow decoding but not under wide decoding.
- Bytes that differ only above bit 2 still match.
- Modifier bytes that differ only in the reserved bits give identical results.

Negative immediates expose missing sign extension. Modifier level values 0 and 3 pick the two register masks. A stall sequence shows that results hold while the next word waits, and that `outValid` drops once the stage drains.

// File: rtl/idec_pkg.sv
`timescale 1ns/1ps
package idec_pkg;

  typedef struct packed {
    logic [31:0] imm;
    logic [7:0]  modByte;
    logic [7:0]  srcByte;
    logic [7:0]  dstByte;
    logic [7:0]  opcode;
  } insn_fields_t;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_L1   = 2'd1,
    LVL_L2   = 2'd2,
    LVL_L3   = 2'd3
  } scratch_lvl_e;

  typedef struct packed {
    logic load;
  } ctrl_strobe_t;

  localparam int IDX_W_WIDE   = 3;
  localparam int IDX_W_NARROW = 2;

endpackage

// File: rtl/idec_ctrl.sv
`timescale 1ns/1ps
module idec_ctrl
  import idec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic         outReady,
  output logic         outValid,
  output ctrl_strobe_t strobe
);

  logic validQ;

  assign inReady     = !validQ || outReady;
  assign strobe.load = inValid && inReady;
  assign outValid    = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  // R8: an accepted word is presented on the next cycle
  p_fire_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R8: the stage drains when nothing new arrives
  p_drain_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);

endmodule

// File: rtl/idec_agen.sv
`timescale 1ns/1ps
module idec_agen
  import idec_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int L1_BITS    = 14,
  parameter int L2_BITS    = 18,
  parameter int ALIGN_BITS = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              useImm,
  input  logic [1:0]        memField,
  output logic [ADDR_W-1:0] addr,
  output scratch_lvl_e      level
);

  localparam logic [ADDR_W-1:0] MASK_L1 =
    {{(ADDR_W-L1_BITS){1'b0}}, {(L1_BITS-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
  localparam logic [ADDR_W-1:0] MASK_L2 =
    {{(ADDR_W-L2_BITS){1'b0}}, {(L2_BITS-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
  localparam logic [ADDR_W-1:0] MASK_L3 =
    {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [ADDR_W-1:0] mask;

  always_comb begin
    if (useImm) begin
      level = LVL_L3;
      mask  = MASK_L3;
    end else if (memField == 2'd0) begin
      level = LVL_L2;
      mask  = MASK_L2;
    end else begin
      level = LVL_L1;
      mask  = MASK_L1;
    end
  end

  assign addr = base & mask;

endmodule

// File: rtl/idec_dpath.sv
`timescale 1ns/1ps
module idec_dpath
  import idec_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 21,
  parameter int L1_BITS    = 14,
  parameter int L2_BITS    = 18,
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [63:0]       inWord,
  input  logic              idxWide,
  output logic [2:0]        rfReadIdx,
  input  logic [DATA_W-1:0] rfReadData,
  output logic [7:0]        opcodeQ,
  output logic [2:0]        dstQ,
  output logic [2:0]        srcQ,
  output logic              useImmQ,
  output logic [DATA_W-1:0] immQ,
  output logic [DATA_W-1:0] srcOpQ,
  output logic [ADDR_W-1:0] addrQ,
  output scratch_lvl_e      levelQ,
  output logic [2:0]        condQ
);

  insn_fields_t fields;
  logic [2:0]        dstIdx, srcIdx;
  logic              useImm;
  logic [DATA_W-1:0] immExt, srcOp;
  logic [ADDR_W-1:0] addrNext;
  scratch_lvl_e      levelNext;
  logic              unusedFieldBits;

  assign fields    = insn_fields_t'(inWord);
  assign rfReadIdx = fields.srcByte[2:0];

  // index width follows the register group in use
  always_comb begin
    if (idxWide) begin
      dstIdx = fields.dstByte[IDX_W_WIDE-1:0];
      srcIdx = fields.srcByte[IDX_W_WIDE-1:0];
    end else begin
      dstIdx = {1'b0, fields.dstByte[IDX_W_NARROW-1:0]};
      srcIdx = {1'b0, fields.srcByte[IDX_W_NARROW-1:0]};
    end
  end

  assign useImm = (dstIdx == srcIdx);
  assign immExt = {{(DATA_W-32){fields.imm[31]}}, fields.imm};
  assign srcOp  = useImm ? immExt : rfReadData;

  assign unusedFieldBits = ^{fields.dstByte[7:3], fields.srcByte[7:3], fields.modByte[7:5]};

  idec_agen #(
    .ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .ALIGN_BITS(ALIGN_BITS)
  ) u_agen (
    .base    (srcOp[ADDR_W-1:0]),
    .useImm  (useImm),
    .memField(fields.modByte[1:0]),
    .addr    (addrNext),
    .level   (levelNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ <= '0;
      dstQ    <= '0;
      srcQ    <= '0;
      useImmQ <= 1'b0;
      immQ    <= '0;
      srcOpQ  <= '0;
      addrQ   <= '0;
      levelQ  <= LVL_NONE;
      condQ   <= '0;
    end else if (strobe.load) begin
      opcodeQ <= fields.opcode;
      dstQ    <= dstIdx;
      srcQ    <= srcIdx;
      useImmQ <= useImm;
      immQ    <= immExt;
      srcOpQ  <= srcOp;
      addrQ   <= addrNext;
      levelQ  <= levelNext;
      condQ   <= fields.modByte[4:2];
    end
  end

  // R6: generated addresses stay aligned
  p_addr_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    addrQ[ALIGN_BITS-1:0] == '0);

  // R5: an immediate source always picks the largest level
  p_imm_l3_r5: assert property (@(posedge clk) disable iff (!rstN)
    useImmQ |-> levelQ == LVL_L3);

  // R5: the smallest level keeps the address inside its window
  p_l1_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ == LVL_L1) |-> addrQ[ADDR_W-1:L1_BITS] == '0);

  // R3: the immediate operand matches the captured immediate
  p_imm_operand_r3: assert property (@(posedge clk) disable iff (!rstN)
    useImmQ |-> srcOpQ == immQ);

endmodule

// File: rtl/insn_decode_agen.sv
`timescale 1ns/1ps
module insn_decode_agen
  import idec_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 21,
  parameter int L1_BITS    = 14,
  parameter int L2_BITS    = 18,
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [63:0]       inWord,
  input  logic              idxWide,
  output logic [2:0]        rfReadIdx,
  input  logic [DATA_W-1:0] rfReadData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outOpcode,
  output logic [2:0]        outDst,
  output logic [2:0]        outSrc,
  output logic              outUseImm,
  output logic [DATA_W-1:0] outImm,
  output logic [DATA_W-1:0] outSrcOperand,
  output logic [ADDR_W-1:0] outMemAddr,
  output logic [1:0]        outLevel,
  output logic [2:0]        outCond
);

  ctrl_strobe_t strobe;
  scratch_lvl_e levelQ;

  idec_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outReady(outReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  idec_dpath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .L1_BITS(L1_BITS),
    .L2_BITS(L2_BITS), .ALIGN_BITS(ALIGN_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inWord    (inWord),
    .idxWide   (idxWide),
    .rfReadIdx (rfReadIdx),
    .rfReadData(rfReadData),
    .opcodeQ   (outOpcode),
    .dstQ      (outDst),
    .srcQ      (outSrc),
    .useImmQ   (outUseImm),
    .immQ      (outImm),
    .srcOpQ    (outSrcOperand),
    .addrQ     (outMemAddr),
    .levelQ    (levelQ),
    .condQ     (outCond)
  );

  assign outLevel = levelQ;

  // R9: a stalled result is held unchanged
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSrcOperand)
                                 && $stable(outMemAddr) && $stable(outOpcode)));

endmodule

// File: tb/insn_decode_agen_tb.sv
`timescale 1ns/1ps
module insn_decode_agen_tb;

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  dst;
    logic [2:0]  src;
    logic        ui;
    logic [63:0] imm;
    logic [63:0] so;
    logic [20:0] addr;
    logic [1:0]  lvl;
    logic [2:0]  cond;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [63:0] inWord = '0;
  logic idxWide = 1'b1;
  logic [2:0] rfReadIdx;
  logic [63:0] rfReadData = '0;
  logic outValid, outReady = 1'b1;
  logic [7:0] outOpcode;
  logic [2:0] outDst, outSrc, outCond;
  logic outUseImm;
  logic [63:0] outImm, outSrcOperand;
  logic [20:0] outMemAddr;
  logic [1:0] outLevel;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  insn_decode_agen u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .idxWide(idxWide), .rfReadIdx(rfReadIdx),
    .rfReadData(rfReadData), .outValid(outValid), .outReady(outReady),
    .outOpcode(outOpcode), .outDst(outDst), .outSrc(outSrc),
    .outUseImm(outUseImm), .outImm(outImm), .outSrcOperand(outSrcOperand),
    .outMemAddr(outMemAddr), .outLevel(outLevel), .outCond(outCond)
  );

  function automatic exp_t model(logic [63:0] w, logic wide, logic [63:0] rf);
    exp_t e;
    logic [7:0] d = w[15:8];
    logic [7:0] s = w[23:16];
    logic [7:0] m = w[31:24];
    logic [20:0] mask;
    e.op  = w[7:0];
    e.dst = wide ? d[2:0] : {1'b0, d[1:0]};
    e.src = wide ? s[2:0] : {1'b0, s[1:0]};
    e.ui  = (e.dst == e.src);
    e.imm = {{32{w[63]}}, w[63:32]};
    e.so  = e.ui ? e.imm : rf;
    if (e.ui) begin e.lvl = 2'd3; mask = 21'h1FFFF8; end
    else if (m[1:0] == 2'd0) begin e.lvl = 2'd2; mask = 21'h03FFF8; end
    else begin e.lvl = 2'd1; mask = 21'h003FF8; end
    e.addr = e.so[20:0] & mask;
    e.cond = m[4:2];
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic checkOut(exp_t e);
    chk(outValid == 1'b1, "R8 valid", 64'(outValid), 64'd1);
    chk(outOpcode == e.op, "R1 opcode", 64'(outOpcode), 64'(e.op));
    chk(outDst == e.dst, "R1 dst", 64'(outDst), 64'(e.dst));
    chk(outSrc == e.src, "R1 src", 64'(outSrc), 64'(e.src));
    chk(outUseImm == e.ui, "R2 useImm", 64'(outUseImm), 64'(e.ui));
    chk(outImm == e.imm, "R3 imm", outImm, e.imm);
    chk(outSrcOperand == e.so, "R3 operand", outSrcOperand, e.so);
    chk(outLevel == e.lvl, "R5 level", 64'(outLevel), 64'(e.lvl));
    chk(outMemAddr == e.addr, "R6 addr", 64'(outMemAddr), 64'(e.addr));
    chk(outCond == e.cond, "R4 cond", 64'(outCond), 64'(e.cond));
  endtask

  // present a word, check the source index, accept on the edge, check outputs
  task automatic send(logic [63:0] w, logic wide, logic [63:0] rf);
    @(negedge clk);
    inValid = 1'b1; inWord = w; idxWide = wide; rfReadData = rf; outReady = 1'b1;
    #0.5;
    chk(rfReadIdx == w[18:16], "R7 rfReadIdx", 64'(rfReadIdx), 64'(w[18:16]));
    @(negedge clk);
    checkOut(model(w, wide, rf));
  endtask

  function automatic logic [63:0] mkWord(logic [31:0] imm, logic [7:0] md,
                                         logic [7:0] s, logic [7:0] d, logic [7:0] op);
    return {imm, md, s, d, op};
  endfunction

  initial begin
    exp_t ea, eb, e1, e2;
    logic [63:0] wa, wb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(outValid == 1'b0, "R10 outValid", 64'(outValid), 64'd0);
    chk(inReady == 1'b1, "R10 inReady", 64'(inReady), 64'd1);
    chk(outMemAddr == '0 && outSrcOperand == '0, "R10 outputs",
        outSrcOperand, 64'd0);
    rstN = 1'b1;

    // R2: match only in bits [1:0]: immediate when narrow, register when wide
    send(mkWord(32'h0000_1234, 8'h01, 8'h06, 8'h02, 8'h5A), 1'b0, 64'hDEAD_BEEF_0012_3458);
    send(mkWord(32'h0000_1234, 8'h01, 8'h06, 8'h02, 8'h5A), 1'b1, 64'hDEAD_BEEF_0012_3458);
    // R2: bytes differ only above bit 2
    send(mkWord(32'h0000_0040, 8'h00, 8'h08, 8'h00, 8'h11), 1'b1, 64'h0);
    // R3: negative immediate sign-extended, R5 largest level
    send(mkWord(32'h8000_0FFF, 8'h03, 8'h05, 8'h05, 8'hFF), 1'b1, 64'h1);
    // R5: level field 0 and 3 on register source
    send(mkWord(32'h0, 8'h00, 8'h03, 8'h01, 8'h22), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    send(mkWord(32'h0, 8'h03, 8'h03, 8'h01, 8'h22), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);

    // R4: reserved modifier bits have no effect
    send(mkWord(32'h7777_1230, 8'h1D, 8'h04, 8'h07, 8'h33), 1'b1, 64'h0123_4567_89AB_CDEF);
    e1 = '{op: outOpcode, dst: outDst, src: outSrc, ui: outUseImm, imm: outImm,
           so: outSrcOperand, addr: outMemAddr, lvl: outLevel, cond: outCond};
    send(mkWord(32'h7777_1230, 8'hFD, 8'h04, 8'h07, 8'h33), 1'b1, 64'h0123_4567_89AB_CDEF);
    e2 = '{op: outOpcode, dst: outDst, src: outSrc, ui: outUseImm, imm: outImm,
           so: outSrcOperand, addr: outMemAddr, lvl: outLevel, cond: outCond};
    chk(e1 == e2, "R4 reserved bits", e2.so, e1.so);

    // random words, source byte often copied from destination byte
    for (int i = 0; i < 400; i++) begin
      logic [63:0] w = {$urandom, $urandom};
      logic [63:0] rf = {$urandom, $urandom};
      if (($urandom % 3) == 0) w[23:16] = w[15:8];
      send(w, 1'(($urandom % 2)), rf);
    end

    // R9 / R8: stall sequence
    wa = mkWord(32'hFFFF_FFF0, 8'h02, 8'h01, 8'h01, 8'hA5);
    wb = mkWord(32'h0000_0000, 8'h00, 8'h02, 8'h03, 8'h5A);
    ea = model(wa, 1'b1, 64'h0);
    eb = model(wb, 1'b1, 64'h0000_0000_0012_3450);
    send(wa, 1'b1, 64'h0);
    outReady = 1'b0; inWord = wb; rfReadData = 64'h0000_0000_0012_3450;
    #0.5;
    chk(inReady == 1'b0, "R8 inReady low in stall", 64'(inReady), 64'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      checkOut(ea);  // R9 held
    end
    outReady = 1'b1;
    @(negedge clk);
    checkOut(eb);
    inValid = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b0, "R8 drain", 64'(outValid), 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule